// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the stall-and-flush controller for an in-order integer pipeline with five stages: fetch, decode, execute, memory and write-back. Every instruction word is 32 bits wide. Decode splits the word into its fields and hands this block the two source register numbers, with a flag for each one that says whether the instruction reads it. The block compares those numbers with the destinations of the older instructions now in execute and in memory. If the decode-stage instruction reads a register that one of them will write, the block holds the PC and the fetch/decode register and puts a no-op into decode/execute. It does this on every cycle until the producer has reached write-back. The register file writes in the first half of a cycle and is read in the second half, so a producer in write-back never causes a conflict. No forwarding is assumed.

A conditional branch resolves in execute. When it is taken, the block clears the two younger instructions, which are in fetch and decode, and steers the PC to the branch target. The target is the branch's incremented PC plus four times its sign-extended word offset. An untaken branch costs nothing. A small state machine records what the controller did on the previous cycle. Its states are `ST_RUN`, `ST_STALL` and `ST_FLUSH`. It uses that record to ignore the decode slot on the cycle right after a flush, because that slot then holds a cleared entry.

Transitions:
- `ST_RUN` → `ST_STALL` on a conflict, and `ST_STALL` → `ST_STALL` while the conflict lasts.
- `ST_STALL` → `ST_RUN` once the conflict is gone.
- Any state → `ST_FLUSH` on a taken branch.
- `ST_FLUSH` → `ST_RUN` when no branch is taken.
- `ST_FLUSH` never goes to `ST_STALL`.
- Reset puts the machine in `ST_RUN`.

Top module: `hazard_ctl`

## Requirements
- R1: When the execute-stage instruction is valid, writes a register, and its destination equals a source field that the decode instruction reads, the block asserts `pc_hold`, `ifid_hold` and `idex_bubble` together and drives `next_pc` equal to `if_pc`.
- R2: A valid, writing memory-stage instruction whose destination matches a read source of the decode instruction causes the same stall as R1.
- R3: A destination of register 0 never causes a stall, in either stage.
- R4: No stall arises from a producer whose write flag is low, from a source field whose read flag is low, or while `id_valid` is low.
- R5: When `ex_valid`, `ex_is_branch` and `ex_cond_true` are all high, the block asserts `ifid_flush` and `idex_flush`. It then drives `next_pc` = `ex_pc_inc` + 4 × signed(`ex_offset`), modulo 2^32.
- R6: An untaken branch (`ex_cond_true` low) causes no flush. With no conflict present, `next_pc` = `if_pc` + 4 and every hold, bubble and flush output is low.
- R7: A taken branch and a conflict in the same cycle produce a flush only. `pc_hold`, `ifid_hold` and `idex_bubble` stay low, and `next_pc` is the branch target.
- R8: On the cycle right after a flush, the decode slot is ignored, so no stall arises from its fields.
- R9: Reset returns the controller to its normal state. A conflict on the first cycle after reset stalls, even if a flush came just before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs_fld | input | 5 | First source register number |
| id_rt_fld | input | 5 | Second source register number |
| id_reads_rs | input | 1 | Decode instruction reads the first source |
| id_reads_rt | input | 1 | Decode instruction reads the second source |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_dst | input | 5 | Execute instruction destination |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wr_en | input | 1 | Memory instruction writes a register |
| mem_dst | input | 5 | Memory instruction destination |
| ex_is_branch | input | 1 | Execute instruction is a conditional branch |
| ex_cond_true | input | 1 | Branch condition evaluated true |
| ex_pc_inc | input | 32 | Incremented PC of the execute instruction |
| ex_offset | input | 16 | Signed word offset of the branch |
| if_pc | input | 32 | PC of the instruction in fetch |
| pc_hold | output | 1 | Keep the PC unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-op into decode/execute because of a stall |
| ifid_flush | output | 1 | Clear the fetch/decode register |
| idex_flush | output | 1 | Clear the decode/execute register |
| next_pc | output | 32 | PC to load at the next edge |

## Verification
The bench drives many cycles of mostly random traffic in which register numbers come from a small set, so matches happen often. On each clock it compares every output with a behavioural model.

Directed cases target the following:
- A producer whose destination is register 0. A design that got this wrong would stall forever on writes that are discarded.
- A match on a second source that is not read. A wrong design would stall for no reason.
- A taken branch in the same cycle as a conflict. A wrong design would hold the PC and lose the redirect.
- A conflict on the cycle after a flush. A wrong design would stall on a cleared slot.
- A negative branch offset. A wrong design that dropped the sign extension would jump forward.
- A reset that arrives right after a flush. A wrong design would keep masking the decode slot across the reset.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STALL = 2'd1,
        ST_FLUSH = 2'd2
    } hz_state_e;
endpackage

// File: rtl/hz_dep_cmp.sv
module hz_dep_cmp #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic          src_used,
    input  logic          ex_valid,
    input  logic          ex_wr_en,
    input  logic [AW-1:0] ex_dst,
    input  logic          mem_valid,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] mem_dst,
    output logic          conflict
);
    logic ex_live, mem_live;

    always_comb begin
        ex_live  = ex_valid  && ex_wr_en  && (ex_dst  != '0);
        mem_live = mem_valid && mem_wr_en && (mem_dst != '0);
        conflict = src_used && ((ex_live  && (ex_dst  == src)) ||
                                (mem_live && (mem_dst == src)));
    end
endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic             ex_valid,
    input  logic             ex_is_branch,
    input  logic             ex_cond_true,
    input  logic [XLEN-1:0]  ex_pc_inc,
    input  logic [OFF_W-1:0] ex_offset,
    output logic             taken,
    output logic [XLEN-1:0]  target
);
    localparam int WORD_SH = 2;
    localparam int EXT_W   = XLEN - OFF_W - WORD_SH;

    logic [XLEN-1:0] byte_off;

    always_comb begin
        byte_off = {{EXT_W{ex_offset[OFF_W-1]}}, ex_offset, {WORD_SH{1'b0}}};
        target   = ex_pc_inc + byte_off;
        taken    = ex_valid && ex_is_branch && ex_cond_true;
    end
endmodule

// File: rtl/hz_ctl_fsm.sv
module hz_ctl_fsm
    import hz_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic            raw_hit,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    input  logic [XLEN-1:0] if_pc,
    output logic            pc_hold,
    output logic            ifid_hold,
    output logic            idex_bubble,
    output logic            ifid_flush,
    output logic            idex_flush,
    output logic [XLEN-1:0] next_pc
);
    localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);

    hz_state_e state_q, state_d;
    logic      slot_hazard;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        slot_hazard = id_valid && raw_hit;
        state_d     = ST_RUN;
        unique case (state_q)
            ST_RUN, ST_STALL: begin
                if (br_taken)         state_d = ST_FLUSH;
                else if (slot_hazard) state_d = ST_STALL;
                else                  state_d = ST_RUN;
            end
            ST_FLUSH: begin
                if (br_taken) state_d = ST_FLUSH;
                else          state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        pc_hold     = 1'b0;
        ifid_hold   = 1'b0;
        idex_bubble = 1'b0;
        ifid_flush  = 1'b0;
        idex_flush  = 1'b0;
        next_pc     = if_pc + INSTR_BYTES;
        unique case (state_d)
            ST_FLUSH: begin
                ifid_flush = 1'b1;
                idex_flush = 1'b1;
                next_pc    = br_target;
            end
            ST_STALL: begin
                pc_hold     = 1'b1;
                ifid_hold   = 1'b1;
                idex_bubble = 1'b1;
                next_pc     = if_pc;
            end
            ST_RUN: begin
                next_pc = if_pc + INSTR_BYTES;
            end
            default: begin
                next_pc = if_pc + INSTR_BYTES;
            end
        endcase
    end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
    parameter int XLEN  = 32,
    parameter int AW    = 5,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [AW-1:0]    id_rs_fld,
    input  logic [AW-1:0]    id_rt_fld,
    input  logic             id_reads_rs,
    input  logic             id_reads_rt,
    input  logic             ex_valid,
    input  logic             ex_wr_en,
    input  logic [AW-1:0]    ex_dst,
    input  logic             mem_valid,
    input  logic             mem_wr_en,
    input  logic [AW-1:0]    mem_dst,
    input  logic             ex_is_branch,
    input  logic             ex_cond_true,
    input  logic [XLEN-1:0]  ex_pc_inc,
    input  logic [OFF_W-1:0] ex_offset,
    input  logic [XLEN-1:0]  if_pc,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             ifid_flush,
    output logic             idex_flush,
    output logic [XLEN-1:0]  next_pc
);
    localparam int N_SRC = 2;

    logic [AW-1:0]   src_num  [N_SRC];
    logic            src_used [N_SRC];
    logic [N_SRC-1:0] src_hit;
    logic            br_taken;
    logic [XLEN-1:0] br_target;

    always_comb begin
        src_num[0]  = id_rs_fld;
        src_num[1]  = id_rt_fld;
        src_used[0] = id_reads_rs;
        src_used[1] = id_reads_rt;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        hz_dep_cmp #(.AW(AW)) u_cmp (
            .src      (src_num[g]),
            .src_used (src_used[g]),
            .ex_valid (ex_valid),
            .ex_wr_en (ex_wr_en),
            .ex_dst   (ex_dst),
            .mem_valid(mem_valid),
            .mem_wr_en(mem_wr_en),
            .mem_dst  (mem_dst),
            .conflict (src_hit[g])
        );
    end

    hz_branch_unit #(.XLEN(XLEN), .OFF_W(OFF_W)) u_br (
        .ex_valid    (ex_valid),
        .ex_is_branch(ex_is_branch),
        .ex_cond_true(ex_cond_true),
        .ex_pc_inc   (ex_pc_inc),
        .ex_offset   (ex_offset),
        .taken       (br_taken),
        .target      (br_target)
    );

    hz_ctl_fsm #(.XLEN(XLEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_valid   (id_valid),
        .raw_hit    (|src_hit),
        .br_taken   (br_taken),
        .br_target  (br_target),
        .if_pc      (if_pc),
        .pc_hold    (pc_hold),
        .ifid_hold  (ifid_hold),
        .idex_bubble(idex_bubble),
        .ifid_flush (ifid_flush),
        .idex_flush (idex_flush),
        .next_pc    (next_pc)
    );
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
    parameter int XLEN  = 32,
    parameter int AW    = 5,
    parameter int OFF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ex_valid,
    input logic             ex_wr_en,
    input logic [AW-1:0]    ex_dst,
    input logic             mem_valid,
    input logic             mem_wr_en,
    input logic [AW-1:0]    mem_dst,
    input logic             ex_is_branch,
    input logic             ex_cond_true,
    input logic [XLEN-1:0]  if_pc,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble,
    input logic             ifid_flush,
    input logic             idex_flush,
    input logic [XLEN-1:0]  next_pc
);
    logic br_on;
    assign br_on = ex_valid && ex_is_branch && ex_cond_true;

    AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ifid_hold && idex_bubble && next_pc == if_pc)); // R1

    AST_ZERO_DST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0 && mem_dst == '0) |-> !pc_hold); // R3

    AST_NO_WRITER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ex_valid && ex_wr_en) && !(mem_valid && mem_wr_en)) |-> !pc_hold); // R4

    AST_TAKEN_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        br_on |-> (ifid_flush && idex_flush)); // R5

    AST_UNTAKEN_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !br_on |-> (!ifid_flush && !idex_flush)); // R6

    AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (!pc_hold && !ifid_hold && !idex_bubble)); // R7

    AST_POST_FLUSH_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |=> !pc_hold); // R8
endmodule

bind hazard_ctl hazard_ctl_chk #(.XLEN(XLEN), .AW(AW), .OFF_W(OFF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_valid    (ex_valid),
    .ex_wr_en    (ex_wr_en),
    .ex_dst      (ex_dst),
    .mem_valid   (mem_valid),
    .mem_wr_en   (mem_wr_en),
    .mem_dst     (mem_dst),
    .ex_is_branch(ex_is_branch),
    .ex_cond_true(ex_cond_true),
    .if_pc       (if_pc),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush),
    .idex_flush  (idex_flush),
    .next_pc     (next_pc)
);

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid, id_reads_rs, id_reads_rt;
    logic [4:0]  id_rs_fld, id_rt_fld, ex_dst, mem_dst;
    logic        ex_valid, ex_wr_en, mem_valid, mem_wr_en;
    logic        ex_is_branch, ex_cond_true;
    logic [31:0] ex_pc_inc, if_pc, next_pc;
    logic [15:0] ex_offset;
    logic        pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit m_after_flush = 1'b0;

    always #5 clk = ~clk;

    hazard_ctl u0 (
        .clk(clk), .rst_n(rst_n),
        .id_valid(id_valid), .id_rs_fld(id_rs_fld), .id_rt_fld(id_rt_fld),
        .id_reads_rs(id_reads_rs), .id_reads_rt(id_reads_rt),
        .ex_valid(ex_valid), .ex_wr_en(ex_wr_en), .ex_dst(ex_dst),
        .mem_valid(mem_valid), .mem_wr_en(mem_wr_en), .mem_dst(mem_dst),
        .ex_is_branch(ex_is_branch), .ex_cond_true(ex_cond_true),
        .ex_pc_inc(ex_pc_inc), .ex_offset(ex_offset), .if_pc(if_pc),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .idex_flush(idex_flush), .next_pc(next_pc)
    );

    task automatic quiet();
        id_valid = 0; id_rs_fld = 0; id_rt_fld = 0; id_reads_rs = 0; id_reads_rt = 0;
        ex_valid = 0; ex_wr_en = 0; ex_dst = 0; mem_valid = 0; mem_wr_en = 0; mem_dst = 0;
        ex_is_branch = 0; ex_cond_true = 0; ex_pc_inc = 32'h100; ex_offset = 0;
        if_pc = 32'h400;
    endtask

    // Behavioural reference: evaluate one cycle, compare at the negedge, advance.
    task automatic step(input string tag);
        bit uses_ex, uses_mem, need, take, e_stall;
        bit [31:0] e_pc;
        longint tgt;
        @(negedge clk);
        uses_ex  = ex_valid && ex_wr_en && ex_dst != 0;
        uses_mem = mem_valid && mem_wr_en && mem_dst != 0;
        need = 0;
        if (id_reads_rs && ((uses_ex && ex_dst == id_rs_fld) || (uses_mem && mem_dst == id_rs_fld))) need = 1;
        if (id_reads_rt && ((uses_ex && ex_dst == id_rt_fld) || (uses_mem && mem_dst == id_rt_fld))) need = 1;
        need = need && id_valid && !m_after_flush;
        take = ex_valid && ex_is_branch && ex_cond_true;
        e_stall = need && !take;
        tgt = longint'(ex_pc_inc) + 4 * longint'($signed(ex_offset));
        if (take)         e_pc = tgt[31:0];
        else if (e_stall) e_pc = if_pc;
        else              e_pc = if_pc + 32'd4;
        n_vec++;
        if (pc_hold !== e_stall || ifid_hold !== e_stall || idex_bubble !== e_stall ||
            ifid_flush !== take || idex_flush !== take || next_pc !== e_pc) begin
            n_bad++;
            $display("FAIL %s: got hold=%b/%b bub=%b fl=%b/%b pc=%h, want hold=%b bub=%b fl=%b pc=%h",
                     tag, pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush, next_pc,
                     e_stall, e_stall, take, e_pc);
        end
        @(posedge clk);
        m_after_flush = rst_n ? take : 1'b0;
        #1;
    endtask

    task automatic ex_prod(input logic [4:0] d, input logic wr);
        ex_valid = 1; ex_wr_en = wr; ex_dst = d;
    endtask

    task automatic id_src(input logic [4:0] a, input logic ra, input logic [4:0] b, input logic rb);
        id_valid = 1; id_rs_fld = a; id_reads_rs = ra; id_rt_fld = b; id_reads_rt = rb;
    endtask

    initial begin
        quiet();
        repeat (2) @(posedge clk);
        #1;
        step("R9 reset quiet");
        rst_n = 1;
        #1;
        step("R6 idle sequential pc");
        // R1 execute producer on each source
        quiet(); id_src(5'd3, 1, 5'd9, 1); ex_prod(5'd3, 1); step("R1 ex rs");
        quiet(); id_src(5'd1, 1, 5'd7, 1); ex_prod(5'd7, 1); step("R1 ex rt");
        // R2 memory producer
        quiet(); id_src(5'd12, 1, 5'd4, 0); mem_valid = 1; mem_wr_en = 1; mem_dst = 5'd12; step("R2 mem rs");
        // R3 register 0
        quiet(); id_src(5'd0, 1, 5'd0, 1); ex_prod(5'd0, 1); mem_valid = 1; mem_wr_en = 1; step("R3 zero dst");
        // R4 masks
        quiet(); id_src(5'd5, 1, 5'd6, 1); ex_prod(5'd5, 0); step("R4 write flag low");
        quiet(); id_src(5'd2, 1, 5'd8, 0); ex_prod(5'd8, 1); step("R4 rt unread");
        quiet(); id_src(5'd8, 0, 5'd2, 1); ex_prod(5'd8, 1); step("R4 rs unread");
        quiet(); id_src(5'd5, 1, 5'd6, 1); id_valid = 0; ex_prod(5'd5, 1); step("R4 id invalid");
        // R6 untaken branch
        quiet(); ex_valid = 1; ex_is_branch = 1; ex_offset = 16'h0010; step("R6 untaken");
        // R5 taken, positive and negative offset
        quiet(); ex_valid = 1; ex_is_branch = 1; ex_cond_true = 1; ex_pc_inc = 32'h44; ex_offset = 16'd7;
        step("R5 taken fwd");
        quiet(); step("R8 idle after flush");
        quiet(); ex_valid = 1; ex_is_branch = 1; ex_cond_true = 1; ex_pc_inc = 32'h200; ex_offset = 16'hFFF0;
        step("R5 taken back");
        // R8 conflict right after flush is ignored
        quiet(); id_src(5'd3, 1, 5'd3, 1); ex_prod(5'd3, 1); step("R8 masked slot");
        quiet(); id_src(5'd3, 1, 5'd3, 1); ex_prod(5'd3, 1); step("R1 stall resumes");
        // R7 flush beats stall
        quiet(); id_src(5'd4, 1, 5'd4, 1); mem_valid = 1; mem_wr_en = 1; mem_dst = 5'd4;
        ex_valid = 1; ex_is_branch = 1; ex_cond_true = 1; ex_pc_inc = 32'h1000; ex_offset = 16'h8000;
        step("R7 flush over stall");
        // R9 reset after flush clears the mask
        quiet(); rst_n = 0; step("R9 in reset");
        rst_n = 1; quiet(); id_src(5'd9, 1, 5'd0, 0); ex_prod(5'd9, 1); step("R9 stall after reset");
        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            id_valid     = ($urandom % 8) != 0;
            id_rs_fld    = 5'($urandom % 4);
            id_rt_fld    = 5'($urandom % 4);
            id_reads_rs  = ($urandom % 4) != 0;
            id_reads_rt  = ($urandom % 2) != 0;
            ex_valid     = ($urandom % 4) != 0;
            ex_wr_en     = ($urandom % 3) != 0;
            ex_dst       = 5'($urandom % 4);
            mem_valid    = ($urandom % 4) != 0;
            mem_wr_en    = ($urandom % 3) != 0;
            mem_dst      = 5'($urandom % 4);
            ex_is_branch = ($urandom % 5) == 0;
            ex_cond_true = ($urandom % 2) != 0;
            ex_pc_inc    = $urandom;
            ex_offset    = 16'($urandom);
            if_pc        = $urandom;
            step("R1 R2 R5 R7 R8 mixed");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule